// File: doc/BRIEF.md
# In-Order Block Commit Controller

This controller keeps the bookkeeping for up to eight atomic instruction blocks that are in flight at once. When a block is allocated, the number of register writes and stores it will produce is declared with it. The counts are fixed because every path through a block yields the same outputs. The tiles then report each output as it happens. The controller counts these reports per slot. A block is finished once its register-write and store counts match what was declared and exactly one branch has been seen.

Commit is a two-phase exchange. When the oldest live block is finished, the controller raises a one-cycle commit broadcast naming that slot. It then gathers one acknowledgement from each of the four register tiles and the four data tiles, in any order and over any number of cycles. When the last acknowledgement arrives, it signals deallocation of the slot. Blocks commit strictly in allocation order. A report that would push a count past its declared total sets a sticky error flag.

Top module: `commit_unit`

## Requirements
- R1: After reset, allocReady is 1, allocSlot is 0, and commitValid, deallocValid and errFlag are all 0.
- R2: Accepted allocations receive slot numbers 0,1,...,7 and then wrap to 0. allocReady is 0 exactly when eight blocks are live. An allocValid presented while allocReady is 0 is not accepted and does not consume a slot number.
- R3: A block is finished only when its register-write count equals its declared total, its store count equals its declared total, and one branch has been reported. The rptKind encoding is 0 for register write, 1 for store, 2 for branch and 3 for no-op (no effect).
- R4: A finished block is not committed while any older block is still live. Commit slots follow allocation order.
- R5: commitValid is combinational from state. It is high for exactly one cycle with commitSlot equal to the oldest live slot, once that block is finished and no commit is pending.
- R6: ackIn bits 0-3 come from the register tiles and bits 4-7 from the data tiles. During a pending commit the bits accumulate across cycles. deallocValid rises in the same cycle as the last missing bit, with deallocSlot equal to the committed slot. Acks that arrive in the commit-broadcast cycle or while no commit is pending are ignored.
- R7: A register-write or store report at a count already equal to its total, or a second branch, sets errFlag one cycle later. The report is not counted. errFlag stays set until reset.
- R8: A report addressed to a slot that holds no live block has no effect: no count, no error and no commit.
- R9: Declared totals can be any value from 0 to 32. A block with both totals at 0 finishes on its branch alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request to allocate a new block |
| allocRegs | input | 6 | Declared register-write total (0..32) |
| allocStores | input | 6 | Declared store total (0..32) |
| allocReady | output | 1 | A free slot exists; the request is accepted this cycle |
| allocSlot | output | 3 | Slot given to an accepted request |
| rptValid | input | 1 | An output report is present |
| rptSlot | input | 3 | Slot the report belongs to |
| rptKind | input | 2 | 0 reg write, 1 store, 2 branch, 3 no-op |
| commitValid | output | 1 | Commit broadcast pulse |
| commitSlot | output | 3 | Slot being committed |
| ackIn | input | 8 | Per-tile commit acknowledgements (3:0 register, 7:4 data) |
| deallocValid | output | 1 | Committed slot is freed at this edge |
| deallocSlot | output | 3 | Slot being freed |
| errFlag | output | 1 | Sticky over-report error |

## Verification
If a per-slot counter is corrupted, the effect shows in the cycle after the last report. The commit pulse is either missing for good, or it appears while a report is still outstanding. A head or tail pointer that steps wrongly shows up at once as the wrong allocSlot or commitSlot number. A wrong occupancy count makes allocReady fall too early or too late at the eighth allocation. A lost acknowledgement bit holds deallocValid low past the cycle of the last acknowledgement. A bit that is not cleared between commits frees the next block one ack phase early.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef enum logic [1:0] {
    RPT_REG    = 2'd0,
    RPT_STORE  = 2'd1,
    RPT_BRANCH = 2'd2,
    RPT_NONE   = 2'd3
  } rpt_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } commit_state_e;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic allocEn;
    logic freeEn;
  } slot_strobe_t;
endpackage

// File: rtl/commit_dp.sv
module commit_dp
  import commit_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slot_strobe_t         strobe,
  input  logic [SLOT_W-1:0]    allocIdx,
  input  logic [SLOT_W-1:0]    freeIdx,
  input  logic [CNT_W-1:0]     allocRegs,
  input  logic [CNT_W-1:0]     allocStores,
  input  logic                 rptValid,
  input  logic [SLOT_W-1:0]    rptSlot,
  input  logic [1:0]           rptKind,
  output logic [NUM_SLOTS-1:0] slotDone,
  output logic                 errFlag
);
  logic [NUM_SLOTS-1:0] ovfVec;
  rpt_kind_e kind;
  assign kind = rpt_kind_e'(rptKind);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [CNT_W-1:0] regCnt, stCnt, regTot, stTot;
    logic brSeen, occBit, hit, incReg, incSt, setBr, ovf;

    assign hit = rptValid && (rptSlot == SLOT_W'(i)) && occBit;

    always_comb begin
      incReg = 1'b0;
      incSt  = 1'b0;
      setBr  = 1'b0;
      ovf    = 1'b0;
      if (hit) begin
        case (kind)
          RPT_REG:    if (regCnt == regTot) ovf = 1'b1; else incReg = 1'b1;
          RPT_STORE:  if (stCnt == stTot)   ovf = 1'b1; else incSt  = 1'b1;
          RPT_BRANCH: if (brSeen)           ovf = 1'b1; else setBr  = 1'b1;
          default:    ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        occBit <= 1'b0;
        regCnt <= '0;
        stCnt  <= '0;
        regTot <= '0;
        stTot  <= '0;
        brSeen <= 1'b0;
      end else if (strobe.allocEn && allocIdx == SLOT_W'(i)) begin
        occBit <= 1'b1;
        regCnt <= '0;
        stCnt  <= '0;
        brSeen <= 1'b0;
        regTot <= allocRegs;
        stTot  <= allocStores;
      end else begin
        if (strobe.freeEn && freeIdx == SLOT_W'(i)) occBit <= 1'b0;
        if (incReg) regCnt <= regCnt + 1'b1;
        if (incSt)  stCnt  <= stCnt + 1'b1;
        if (setBr)  brSeen <= 1'b1;
      end
    end

    assign ovfVec[i]   = ovf;
    assign slotDone[i] = occBit && brSeen && (regCnt == regTot) && (stCnt == stTot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= errFlag | (|ovfVec);
  end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int NUM_TILES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [NUM_SLOTS-1:0] slotDone,
  input  logic [NUM_TILES-1:0] ackIn,
  output logic                 allocReady,
  output logic [SLOT_W-1:0]    allocSlot,
  output logic                 commitValid,
  output logic [SLOT_W-1:0]    commitSlot,
  output logic                 deallocValid,
  output logic [SLOT_W-1:0]    deallocSlot,
  output slot_strobe_t         strobe
);
  localparam int USED_W = $clog2(NUM_SLOTS + 1);
  localparam logic [USED_W-1:0] FULL_CNT = USED_W'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NUM_SLOTS - 1);

  commit_state_e state;
  logic [SLOT_W-1:0]    head, tail;
  logic [USED_W-1:0]    used;
  logic [NUM_TILES-1:0] ackSeen;
  logic                 allocOk;

  assign allocReady   = (used != FULL_CNT);
  assign allocOk      = allocValid && allocReady;
  assign allocSlot    = tail;
  assign commitSlot   = head;
  assign deallocSlot  = head;
  assign commitValid  = (state == ST_IDLE) && slotDone[head];
  assign deallocValid = (state == ST_WAIT) && (&(ackSeen | ackIn));

  assign strobe.allocEn = allocOk;
  assign strobe.freeEn  = deallocValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      head    <= '0;
      tail    <= '0;
      used    <= '0;
      ackSeen <= '0;
    end else begin
      if (allocOk) tail <= (tail == LAST_IDX) ? '0 : tail + 1'b1;
      case ({allocOk, deallocValid})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: ;
      endcase
      case (state)
        ST_IDLE: if (commitValid) begin
          state   <= ST_WAIT;
          ackSeen <= '0;
        end
        ST_WAIT: if (deallocValid) begin
          state   <= ST_IDLE;
          ackSeen <= '0;
          head    <= (head == LAST_IDX) ? '0 : head + 1'b1;
        end else begin
          ackSeen <= ackSeen | ackIn;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/commit_unit.sv
module commit_unit
  import commit_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_RT    = 4,
  parameter int NUM_DT    = 4,
  parameter int MAX_OUT   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocValid,
  input  logic [$clog2(MAX_OUT+1)-1:0] allocRegs,
  input  logic [$clog2(MAX_OUT+1)-1:0] allocStores,
  output logic                     allocReady,
  output logic [$clog2(NUM_SLOTS)-1:0] allocSlot,
  input  logic                     rptValid,
  input  logic [$clog2(NUM_SLOTS)-1:0] rptSlot,
  input  logic [1:0]               rptKind,
  output logic                     commitValid,
  output logic [$clog2(NUM_SLOTS)-1:0] commitSlot,
  input  logic [NUM_RT+NUM_DT-1:0] ackIn,
  output logic                     deallocValid,
  output logic [$clog2(NUM_SLOTS)-1:0] deallocSlot,
  output logic                     errFlag
);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int CNT_W     = $clog2(MAX_OUT + 1);
  localparam int NUM_TILES = NUM_RT + NUM_DT;

  slot_strobe_t         strobe;
  logic [NUM_SLOTS-1:0] slotDone;

  commit_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .NUM_TILES(NUM_TILES)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .slotDone(slotDone), .ackIn(ackIn),
    .allocReady(allocReady), .allocSlot(allocSlot), .commitValid(commitValid),
    .commitSlot(commitSlot), .deallocValid(deallocValid), .deallocSlot(deallocSlot),
    .strobe(strobe)
  );

  commit_dp #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocSlot), .freeIdx(deallocSlot),
    .allocRegs(allocRegs), .allocStores(allocStores), .rptValid(rptValid),
    .rptSlot(rptSlot), .rptKind(rptKind), .slotDone(slotDone), .errFlag(errFlag)
  );
endmodule

// File: rtl/commit_chk.sv
module commit_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocValid,
  input logic              allocReady,
  input logic              commitValid,
  input logic [SLOT_W-1:0] commitSlot,
  input logic              deallocValid,
  input logic [SLOT_W-1:0] deallocSlot,
  input logic              errFlag
);
  localparam int OCC_W = $clog2(NUM_SLOTS + 1);
  logic [OCC_W-1:0]  occ;
  logic [SLOT_W-1:0] nextCommit;
  logic              pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ        <= '0;
      nextCommit <= '0;
      pending    <= 1'b0;
    end else begin
      occ <= occ + OCC_W'(allocValid && allocReady) - OCC_W'(deallocValid);
      if (commitValid) pending <= 1'b1;
      if (deallocValid) begin
        pending    <= 1'b0;
        nextCommit <= (nextCommit == SLOT_W'(NUM_SLOTS - 1)) ? '0 : nextCommit + 1'b1;
      end
    end
  end

  p_ready_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    allocReady == (occ != OCC_W'(NUM_SLOTS)));
  p_commit_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> occ != '0);
  p_commit_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> commitSlot == nextCommit);
  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !commitValid);
  p_no_double_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> !pending);
  p_dealloc_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    deallocValid |-> (pending && deallocSlot == nextCommit));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind commit_unit commit_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W($clog2(NUM_SLOTS))) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .commitValid(commitValid), .commitSlot(commitSlot), .deallocValid(deallocValid),
  .deallocSlot(deallocSlot), .errFlag(errFlag)
);

// File: tb/tb_commit_unit.sv
module tb_commit_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [5:0] allocRegs = '0, allocStores = '0;
  logic allocReady;
  logic [2:0] allocSlot, commitSlot, deallocSlot;
  logic rptValid = 1'b0;
  logic [2:0] rptSlot = '0;
  logic [1:0] rptKind = '0;
  logic commitValid, deallocValid, errFlag;
  logic [7:0] ackIn = '0;

  int checks = 0, errors = 0, nextSlot = 0;

  always #5 clk = ~clk;

  commit_unit dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocRegs(allocRegs),
    .allocStores(allocStores), .allocReady(allocReady), .allocSlot(allocSlot),
    .rptValid(rptValid), .rptSlot(rptSlot), .rptKind(rptKind),
    .commitValid(commitValid), .commitSlot(commitSlot), .ackIn(ackIn),
    .deallocValid(deallocValid), .deallocSlot(deallocSlot), .errFlag(errFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doAlloc(input int rw, input int st, output int slot);
    @(negedge clk);
    allocValid = 1'b1; allocRegs = 6'(rw); allocStores = 6'(st);
    #1 slot = int'(allocSlot);
    chk(allocReady && slot == nextSlot, "R2 alloc slot", slot, nextSlot);
    nextSlot = (nextSlot + 1) % 8;
    @(posedge clk); #1 allocValid = 1'b0;
  endtask

  task automatic doRpt(input int slot, input int kind);
    @(negedge clk);
    rptValid = 1'b1; rptSlot = 3'(slot); rptKind = 2'(kind);
    @(posedge clk); #1 rptValid = 1'b0;
  endtask

  task automatic expectCommit(input int slot, input string req);
    @(negedge clk);
    chk(commitValid && int'(commitSlot) == slot, req, commitValid ? int'(commitSlot) : -1, slot);
    @(negedge clk);
    chk(!commitValid, "R5 commit pulse one cycle", int'(commitValid), 0);
  endtask

  task automatic ackBlock(input int slot);
    @(negedge clk); ackIn = 8'h0F;
    #1 chk(!deallocValid, "R6 partial acks", int'(deallocValid), 0);
    @(posedge clk); #1 ackIn = 8'h00;
    @(negedge clk); ackIn = 8'hF0;
    #1 chk(deallocValid && int'(deallocSlot) == slot, "R6 dealloc on last ack",
           deallocValid ? int'(deallocSlot) : -1, slot);
    @(posedge clk); #1 ackIn = 8'h00;
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(allocReady, "R1 allocReady", int'(allocReady), 1);
    chk(allocSlot == 3'd0, "R1 allocSlot", int'(allocSlot), 0);
    chk(!commitValid && !deallocValid, "R1 commit/dealloc idle",
        int'({commitValid, deallocValid}), 0);
    chk(!errFlag, "R1 errFlag", int'(errFlag), 0);
  endtask

  task automatic tBasic();
    int s;
    doAlloc(2, 1, s);
    doRpt(s, 0); doRpt(s, 0); doRpt(s, 1);
    @(negedge clk);
    chk(!commitValid, "R3 no commit without branch", int'(commitValid), 0);
    doRpt(s, 2);
    expectCommit(s, "R3 commit when counts met");
    ackBlock(s);
  endtask

  task automatic tAckTiming();
    int s;
    doAlloc(0, 0, s);
    doRpt(s, 2);
    @(negedge clk); ackIn = 8'hFF;
    chk(commitValid, "R5 commit raised", int'(commitValid), 1);
    @(posedge clk); #1 ackIn = 8'h00;
    @(negedge clk);
    chk(!deallocValid, "R6 acks in broadcast cycle ignored", int'(deallocValid), 0);
    ackBlock(s);
  endtask

  task automatic tInOrder();
    int a, b;
    doAlloc(1, 0, a);
    doAlloc(0, 0, b);
    doRpt(b, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!commitValid, "R4 younger waits", int'(commitValid), 0);
    end
    doRpt(a, 2); doRpt(a, 0);
    expectCommit(a, "R4 older commits first");
    ackBlock(a);
    expectCommit(b, "R4 younger after older freed");
    ackBlock(b);
  endtask

  task automatic tMaxCounts();
    int s;
    doAlloc(32, 32, s);
    for (int k = 0; k < 32; k++) doRpt(s, 0);
    for (int k = 0; k < 31; k++) doRpt(s, 1);
    doRpt(s, 2);
    @(negedge clk);
    chk(!commitValid, "R9 one store short", int'(commitValid), 0);
    doRpt(s, 1);
    expectCommit(s, "R9 commit at 32/32");
    ackBlock(s);
    chk(!errFlag, "R9 no error at max", int'(errFlag), 0);
  endtask

  task automatic tIgnore();
    int s;
    doRpt(6, 2);
    @(negedge clk);
    chk(!commitValid && !errFlag, "R8 report to free slot ignored",
        int'({commitValid, errFlag}), 0);
    doAlloc(0, 0, s);
    doRpt(s, 3);
    @(negedge clk);
    chk(!commitValid, "R3 no-op kind has no effect", int'(commitValid), 0);
    doRpt(s, 2);
    expectCommit(s, "R8 block commits normally");
    ackBlock(s);
  endtask

  task automatic tFull();
    int s, first;
    first = nextSlot;
    for (int k = 0; k < 8; k++) doAlloc(0, 0, s);
    @(negedge clk); allocValid = 1'b1;
    #1 chk(!allocReady, "R2 full refuses", int'(allocReady), 0);
    @(posedge clk); #1 allocValid = 1'b0;
    doRpt(first, 2);
    expectCommit(first, "R2 head commits while full");
    ackBlock(first);
    @(negedge clk);
    chk(allocReady, "R2 ready after free", int'(allocReady), 1);
    doAlloc(0, 0, s);
    for (int k = 1; k <= 8; k++) begin
      int t;
      t = (first + k) % 8;
      doRpt(t, 2);
      expectCommit(t, "R4 drain order");
      ackBlock(t);
    end
  endtask

  task automatic tError();
    int s;
    doAlloc(1, 0, s);
    doRpt(s, 0);
    @(negedge clk);
    chk(!errFlag, "R7 no error at total", int'(errFlag), 0);
    doRpt(s, 0);
    @(negedge clk);
    chk(errFlag, "R7 overflow sets flag", int'(errFlag), 1);
    doRpt(s, 2);
    expectCommit(s, "R7 overflow not counted");
    ackBlock(s);
    repeat (3) @(negedge clk);
    chk(errFlag, "R7 flag sticky", int'(errFlag), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tBasic();
    tAckTiming();
    tInOrder();
    tMaxCounts();
    tIgnore();
    tFull();
    tError();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule